// File: doc/BRIEF.md
# OTP Page Load Host Sequencer

This block sits on the host side of a NAND flash device that is controlled through 16-bit registers at fixed addresses. A start pulse makes it program the die select bits and switch the device into its one-time-programmable (OTP) area. It then sets the page and sector address, forces the fixed buffer placement that OTP loads require, and issues a load command. When the device raises its interrupt flag, the sequencer reports that the OTP page sits in the buffer RAM and can be read by the host.

All device traffic goes through one simple synchronous bus master with a single transaction in flight. After each command the sequencer polls the interrupt-status register until it sees the flag rise from 0 to 1. A programmable poll budget stops a wait that never ends and moves the block into an error state. The device leaves OTP mode only through a reset. A separate exit request therefore writes a core reset command, waits for the flag, and returns the block to idle. The exit request works from both the OTP-active state and the error state.

Top module: `otp_load_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `otp_active_o` and `err_o` are 0, and neither bus strobe is asserted until a start is accepted.
- R2: A start from idle with auto mode off writes, in this order: F100h ← die word, F101h ← die word (the die word is `die_sel_i` in bit 15 and zeros below it), F241h ← 0000h, F220h ← 0065h, a flag wait, F107h ← `page_sector_i`, F200h ← 0800h, F241h ← 0000h, F220h ← 0000h, and a final flag wait.
- R3: When `auto_int_i` is high at the start, both writes of 0000h to F241h are left out and the rest of the R2 order is kept.
- R4: Every flag wait consists only of reads of F241h. The wait ends on the first read whose bit 15 is 1 when the read before it in the same wait had bit 15 at 0. The first read of a wait is compared as if it followed a 1, so a flag that is already high does not end the wait.
- R5: When `poll_limit_i` reads of one wait (at least one read) pass without ending it, the block enters an error state. In that state `err_o` is 1, `busy_o` is 0 and no bus transaction is issued.
- R6: When a load ends, `done_o` is 1 for exactly one cycle, and in that cycle `otp_active_o` becomes 1. `otp_active_o` then stays 1 until an exit is accepted.
- R7: `busy_o` is 1 from an accepted start until the load ends. A start pulse is ignored while busy and while in the error state.
- R8: A start accepted while OTP-active skips the OTP access command and its wait. It writes F100h, F101h, F107h, F200h, the clear of F241h (unless in auto mode) and F220h ← 0000h, then waits.
- R9: An exit request in the OTP-active state writes F220h ← `RESET_CMD` (default 00F0h), performs a flag wait, then returns to idle. An exit request in idle or while busy is ignored.
- R10: At most one strobe is high at a time. Once raised, a strobe stays high, with its address and data unchanged, until the cycle in which `bus_ready_i` is sampled high.
- R11: An exit request in the error state runs the same reset-command sequence as R9 and ends in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one OTP page load |
| exit_i | input | 1 | Request to leave OTP mode with a core reset |
| auto_int_i | input | 1 | Device clears its flag itself; skip the clear writes |
| die_sel_i | input | 1 | Die select written to bit 15 of F100h and F101h |
| page_sector_i | input | 16 | Page and sector word for F107h |
| poll_limit_i | input | 16 | Maximum reads allowed in one flag wait |
| bus_addr_o | output | 16 | Register address |
| bus_wdata_o | output | 16 | Write data |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_rdata_i | input | 16 | Read data, valid while ready is high |
| bus_ready_i | input | 1 | Transaction completes when sampled high |
| busy_o | output | 1 | A load or exit sequence is running |
| done_o | output | 1 | One-cycle pulse when a load ends |
| otp_active_o | output | 1 | Device is in OTP mode with the page loaded |
| err_o | output | 1 | A flag wait ran out of polls |

## Verification
The load is run with auto mode both off and on, with different die and page words and with bus ready delays of zero to two cycles. These runs show that the clear writes depend on the mode and that the captured words reach the right registers. A second load started from the OTP-active state shows whether the access command is correctly skipped. An extra start pulse sent mid-run shows whether pulses are dropped while busy. The device model keeps its flag low for a set number of reads and starts high after reset. This separates true edge detection from level detection. It also fixes the exact number of polls per wait. A flag that never rises, combined with a small poll budget, tests the error path, the quiet error state and the exit from error.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int FLAG_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] REG_BLK  = 16'hF100;
  localparam logic [ADDR_W-1:0] REG_DSEL = 16'hF101;
  localparam logic [ADDR_W-1:0] REG_PAGE = 16'hF107;
  localparam logic [ADDR_W-1:0] REG_BUF  = 16'hF200;
  localparam logic [ADDR_W-1:0] REG_CMD  = 16'hF220;
  localparam logic [ADDR_W-1:0] REG_INT  = 16'hF241;

  localparam logic [DATA_W-1:0] CMD_OTP  = 16'h0065;
  localparam logic [DATA_W-1:0] CMD_LOAD = 16'h0000;
  localparam logic [DATA_W-1:0] BUF_OTP  = 16'h0800;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FBA, ST_DBS, ST_CLR1, ST_OTP, ST_WAIT1, ST_PAGE, ST_BUF,
    ST_CLR2, ST_LOAD, ST_WAIT2, ST_ACTIVE, ST_RST, ST_WAIT3, ST_ERR
  } seq_state_t;

  function automatic logic [DATA_W-1:0] die_word(input logic die);
    die_word = {die, {(DATA_W-1){1'b0}}};
  endfunction

  function automatic logic rise_seen(input logic prev, input logic now);
    rise_seen = !prev && now;
  endfunction

  function automatic logic poll_spent(input logic [15:0] cnt, input logic [15:0] lim);
    poll_spent = ({1'b0, cnt} + 17'd1) >= {1'b0, lim};
  endfunction

endpackage

// File: rtl/otp_bus_port.sv
module otp_bus_port
  import otp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              idle_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] ack_rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i
);
  logic              active_q, rd_q, ack_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      ack_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      ack_q <= 1'b0;
      if (!active_q) begin
        if (req_i) begin
          active_q <= 1'b1;
          rd_q     <= req_rd_i;
          addr_q   <= req_addr_i;
          wdata_q  <= req_wdata_i;
        end
      end else if (bus_ready_i) begin
        active_q <= 1'b0;
        ack_q    <= 1'b1;
        rdata_q  <= bus_rdata_i;
      end
    end
  end

  assign idle_o      = !active_q && !ack_q;
  assign ack_o       = ack_q;
  assign ack_rdata_o = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_wr_o    = active_q && !rd_q;
  assign bus_rd_o    = active_q && rd_q;
endmodule

// File: rtl/otp_poll_ctl.sv
module otp_poll_ctl
  import otp_seq_pkg::*;
#(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              sample_i,
  input  logic              flag_i,
  input  logic [POLL_W-1:0] limit_i,
  output logic              edge_o,
  output logic              expire_o
);
  logic              prev_q;
  logic [POLL_W-1:0] cnt_q;
  logic [15:0]       cnt_ext, lim_ext;

  assign cnt_ext  = 16'(cnt_q);
  assign lim_ext  = 16'(limit_i);
  assign edge_o   = sample_i && rise_seen(prev_q, flag_i);
  assign expire_o = sample_i && !edge_o && poll_spent(cnt_ext, lim_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else if (arm_i) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else if (sample_i) begin
      prev_q <= flag_i;
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/otp_step_decode.sv
module otp_step_decode
  import otp_seq_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_CMD = 16'h00F0
) (
  input  seq_state_t        state_i,
  input  logic              die_i,
  input  logic [DATA_W-1:0] page_sector_i,
  output logic              is_bus_o,
  output logic              is_rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_comb begin
    is_bus_o = 1'b1;
    is_rd_o  = 1'b0;
    addr_o   = '0;
    wdata_o  = '0;
    case (state_i)
      ST_FBA:   begin addr_o = REG_BLK;  wdata_o = die_word(die_i); end
      ST_DBS:   begin addr_o = REG_DSEL; wdata_o = die_word(die_i); end
      ST_CLR1,
      ST_CLR2:  begin addr_o = REG_INT;  wdata_o = '0; end
      ST_OTP:   begin addr_o = REG_CMD;  wdata_o = CMD_OTP; end
      ST_PAGE:  begin addr_o = REG_PAGE; wdata_o = page_sector_i; end
      ST_BUF:   begin addr_o = REG_BUF;  wdata_o = BUF_OTP; end
      ST_LOAD:  begin addr_o = REG_CMD;  wdata_o = CMD_LOAD; end
      ST_RST:   begin addr_o = REG_CMD;  wdata_o = RESET_CMD; end
      ST_WAIT1,
      ST_WAIT2,
      ST_WAIT3: begin addr_o = REG_INT;  is_rd_o = 1'b1; end
      default:  is_bus_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/otp_load_seq.sv
module otp_load_seq
  import otp_seq_pkg::*;
#(
  parameter int                POLL_W    = 16,
  parameter logic [DATA_W-1:0] RESET_CMD = 16'h00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              exit_i,
  input  logic              auto_int_i,
  input  logic              die_sel_i,
  input  logic [DATA_W-1:0] page_sector_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              otp_active_o,
  output logic              err_o
);
  seq_state_t        state_q, state_d;
  logic              die_q, auto_q, reload_q, done_q;
  logic [DATA_W-1:0] ps_q;

  logic              step_bus, step_rd, port_idle, port_ack;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] step_wdata, port_rdata;

  // Named internal events, also used by the bound checker
  logic in_wait, poll_sample, edge_hit, timeout_hit, start_accept, exit_accept, auto_run;

  assign in_wait      = (state_q == ST_WAIT1) || (state_q == ST_WAIT2) || (state_q == ST_WAIT3);
  assign poll_sample  = port_ack && in_wait;
  assign exit_accept  = exit_i && ((state_q == ST_ACTIVE) || (state_q == ST_ERR));
  assign start_accept = start_i && !exit_accept &&
                        ((state_q == ST_IDLE) || (state_q == ST_ACTIVE));
  assign auto_run     = auto_q;

  otp_step_decode #(.RESET_CMD(RESET_CMD)) u_decode (
    .state_i       (state_q),
    .die_i         (die_q),
    .page_sector_i (ps_q),
    .is_bus_o      (step_bus),
    .is_rd_o       (step_rd),
    .addr_o        (step_addr),
    .wdata_o       (step_wdata)
  );

  otp_bus_port u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (step_bus && port_idle),
    .req_rd_i    (step_rd),
    .req_addr_i  (step_addr),
    .req_wdata_i (step_wdata),
    .idle_o      (port_idle),
    .ack_o       (port_ack),
    .ack_rdata_o (port_rdata),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_wr_o    (bus_wr_o),
    .bus_rd_o    (bus_rd_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ready_i (bus_ready_i)
  );

  otp_poll_ctl #(.POLL_W(POLL_W)) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (!in_wait),
    .sample_i (poll_sample),
    .flag_i   (port_rdata[FLAG_BIT]),
    .limit_i  (poll_limit_i),
    .edge_o   (edge_hit),
    .expire_o (timeout_hit)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_accept) state_d = ST_FBA;
      ST_ACTIVE: if (exit_accept) state_d = ST_RST;
                 else if (start_accept) state_d = ST_FBA;
      ST_ERR:    if (exit_accept) state_d = ST_RST;
      ST_FBA:    if (port_ack) state_d = ST_DBS;
      ST_DBS:    if (port_ack) state_d = reload_q ? ST_PAGE : (auto_q ? ST_OTP : ST_CLR1);
      ST_CLR1:   if (port_ack) state_d = ST_OTP;
      ST_OTP:    if (port_ack) state_d = ST_WAIT1;
      ST_PAGE:   if (port_ack) state_d = ST_BUF;
      ST_BUF:    if (port_ack) state_d = auto_q ? ST_LOAD : ST_CLR2;
      ST_CLR2:   if (port_ack) state_d = ST_LOAD;
      ST_LOAD:   if (port_ack) state_d = ST_WAIT2;
      ST_RST:    if (port_ack) state_d = ST_WAIT3;
      ST_WAIT1:  if (edge_hit) state_d = ST_PAGE;
                 else if (timeout_hit) state_d = ST_ERR;
      ST_WAIT2:  if (edge_hit) state_d = ST_ACTIVE;
                 else if (timeout_hit) state_d = ST_ERR;
      ST_WAIT3:  if (edge_hit) state_d = ST_IDLE;
                 else if (timeout_hit) state_d = ST_ERR;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      die_q    <= 1'b0;
      auto_q   <= 1'b0;
      reload_q <= 1'b0;
      ps_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_WAIT2) && edge_hit;
      if (start_accept) begin
        die_q    <= die_sel_i;
        auto_q   <= auto_int_i;
        ps_q     <= page_sector_i;
        reload_q <= (state_q == ST_ACTIVE);
      end
    end
  end

  assign busy_o       = !((state_q == ST_IDLE) || (state_q == ST_ACTIVE) || (state_q == ST_ERR));
  assign done_o       = done_q;
  assign otp_active_o = (state_q == ST_ACTIVE);
  assign err_o        = (state_q == ST_ERR);
endmodule

// File: rtl/otp_load_seq_chk.sv
module otp_load_seq_chk
  import otp_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_o,
  input logic              bus_rd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ready_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              otp_active_o,
  input logic              err_o,
  input logic              timeout_hit,
  input logic              auto_run
);
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_o && bus_rd_o));

  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o || bus_rd_o) && !bus_ready_i |=>
      (bus_wr_o || bus_rd_o) && $stable(bus_addr_o) && $stable(bus_wdata_o));

  a_r6_done_with_active: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> otp_active_o);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_timeout_to_err: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> err_o);

  a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o && !bus_wr_o && !bus_rd_o);

  a_r3_auto_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && auto_run && bus_wr_o |-> bus_addr_o != REG_INT);

  a_r2_buffer_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o && bus_addr_o == REG_BUF |-> bus_wdata_o == BUF_OTP);

  a_r4_poll_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |-> bus_addr_o == REG_INT);
endmodule

bind otp_load_seq otp_load_seq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr_o     (bus_wr_o),
  .bus_rd_o     (bus_rd_o),
  .bus_addr_o   (bus_addr_o),
  .bus_wdata_o  (bus_wdata_o),
  .bus_ready_i  (bus_ready_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .otp_active_o (otp_active_o),
  .err_o        (err_o),
  .timeout_hit  (timeout_hit),
  .auto_run     (auto_run)
);

// File: tb/otp_load_seq_tb_top.sv
module otp_load_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, exit_i = 1'b0, auto_int_i = 1'b0, die_sel_i = 1'b0;
  logic [15:0] page_sector_i = '0, poll_limit_i = 16'd100;
  logic [15:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic        bus_wr_o, bus_rd_o, bus_ready_i;
  logic        busy_o, done_o, otp_active_o, err_o;

  always #2 clk = ~clk;

  otp_load_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .exit_i(exit_i),
    .auto_int_i(auto_int_i), .die_sel_i(die_sel_i), .page_sector_i(page_sector_i),
    .poll_limit_i(poll_limit_i), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .bus_rdata_i(bus_rdata_i),
    .bus_ready_i(bus_ready_i), .busy_o(busy_o), .done_o(done_o),
    .otp_active_o(otp_active_o), .err_o(err_o)
  );

  int n_checks = 0, n_fail = 0;
  int dly = 0, k_reads = 1;
  int wcnt = 0, pend = 0;
  bit flag = 1'b1;
  int wr_total = 0, rd_total = 0, done_cnt = 0, hold_bad = 0;
  logic [31:0] exp_q[$];
  logic        pend_prev = 1'b0;
  logic [15:0] addr_prev = '0;
  logic [15:0] data_prev = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Device model: ready after dly wait cycles; flag low for k_reads reads after a command
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ready_i <= 1'b0;
      bus_rdata_i <= '0;
      wcnt = 0; pend = 0; flag = 1'b1;
    end else if ((bus_wr_o || bus_rd_o) && !bus_ready_i) begin
      if (wcnt >= dly) begin
        bus_ready_i <= 1'b1;
        wcnt = 0;
        if (bus_rd_o) begin
          bus_rdata_i <= {flag, 15'b0};
          if (pend > 0) begin
            pend--;
            if (pend == 0) flag = 1'b1;
          end
        end else if (bus_addr_o == 16'hF220) begin
          flag = 1'b0;
          pend = k_reads;
        end else if (bus_addr_o == 16'hF241) begin
          flag = 1'b0;
        end
      end else wcnt++;
    end else bus_ready_i <= 1'b0;
  end

  // Transaction monitor against the expected write queue
  always @(posedge clk) begin
    if (rst_n) begin
      if (done_o) done_cnt++;
      if (pend_prev && !((bus_wr_o || bus_rd_o) && bus_addr_o == addr_prev &&
                         bus_wdata_o == data_prev)) hold_bad++;
      pend_prev = (bus_wr_o || bus_rd_o) && !bus_ready_i;
      addr_prev = bus_addr_o;
      data_prev = bus_wdata_o;
      if (bus_ready_i && bus_wr_o) begin
        wr_total++;
        if (exp_q.size() == 0)
          chk(1'b0, "R2", "unexpected write", {bus_addr_o, bus_wdata_o}, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk({bus_addr_o, bus_wdata_o} == e, "R2", "write addr/data",
              {bus_addr_o, bus_wdata_o}, e);
        end
      end
      if (bus_ready_i && bus_rd_o) begin
        rd_total++;
        if (bus_addr_o != 16'hF241) chk(1'b0, "R4", "poll address", bus_addr_o, 16'hF241);
      end
    end
  end

  task automatic push(input logic [15:0] a, input logic [15:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic pulse(input bit which);
    @(negedge clk);
    if (which) exit_i = 1'b1; else start_i = 1'b1;
    @(negedge clk);
    exit_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_load(input bit die, input logic [15:0] ps, input bit autom,
                             input bit reload);
    push(16'hF100, {die, 15'b0});
    push(16'hF101, {die, 15'b0});
    if (!reload) begin
      if (!autom) push(16'hF241, 16'h0000);
      push(16'hF220, 16'h0065);
    end
    push(16'hF107, ps);
    push(16'hF200, 16'h0800);
    if (!autom) push(16'hF241, 16'h0000);
    push(16'hF220, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int rd0, wr0, d0;
    idle_cycles(3);
    // R1 reset state
    chk(!busy_o && !done_o && !otp_active_o && !err_o, "R1", "outputs in reset",
        {busy_o, done_o, otp_active_o, err_o}, 0);
    rst_n = 1'b1;
    idle_cycles(3);
    chk(!bus_wr_o && !bus_rd_o && !busy_o, "R1", "idle after reset",
        {bus_wr_o, bus_rd_o, busy_o}, 0);

    // R2 R4 R6: full load, auto off
    dly = 1; k_reads = 2; die_sel_i = 1'b1; page_sector_i = 16'h1234; auto_int_i = 1'b0;
    expect_load(1'b1, 16'h1234, 1'b0, 1'b0);
    rd0 = rd_total; d0 = done_cnt;
    pulse(1'b0);
    idle_cycles(1);
    chk(busy_o == 1'b1, "R7", "busy after start", busy_o, 1);
    while (!otp_active_o) @(negedge clk);
    idle_cycles(20);
    chk(exp_q.size() == 0, "R2", "writes remaining", exp_q.size(), 0);
    chk(rd_total - rd0 == 2 * (k_reads + 1), "R4", "poll reads", rd_total - rd0, 2 * (k_reads + 1));
    chk(done_cnt - d0 == 1, "R6", "done pulse cycles", done_cnt - d0, 1);
    chk(otp_active_o && !busy_o, "R6", "otp active held", {otp_active_o, busy_o}, 2);

    // R8 R7: reload from OTP-active, extra start mid-run ignored
    dly = 0; die_sel_i = 1'b0; page_sector_i = 16'h0042;
    expect_load(1'b0, 16'h0042, 1'b0, 1'b1);
    d0 = done_cnt;
    pulse(1'b0);
    idle_cycles(3);
    page_sector_i = 16'hFFFF;
    pulse(1'b0);
    while (!otp_active_o) @(negedge clk);
    idle_cycles(30);
    chk(exp_q.size() == 0, "R8", "reload writes remaining", exp_q.size(), 0);
    chk(done_cnt - d0 == 1, "R7", "single load despite extra start", done_cnt - d0, 1);

    // R9: exit from OTP-active
    dly = 2; k_reads = 1;
    push(16'hF220, 16'h00F0);
    rd0 = rd_total;
    pulse(1'b1);
    while (busy_o || otp_active_o) @(negedge clk);
    idle_cycles(5);
    chk(exp_q.size() == 0, "R9", "reset command written", exp_q.size(), 0);
    chk(rd_total - rd0 == k_reads + 1, "R9", "exit poll reads", rd_total - rd0, k_reads + 1);
    chk(!busy_o && !otp_active_o && !err_o, "R9", "back to idle",
        {busy_o, otp_active_o, err_o}, 0);
    wr0 = wr_total;
    pulse(1'b1);
    idle_cycles(20);
    chk(wr_total == wr0 && !busy_o, "R9", "exit ignored in idle", wr_total - wr0, 0);

    // R3: auto mode, flag starts high after previous wait
    dly = 0; k_reads = 1; auto_int_i = 1'b1; die_sel_i = 1'b1; page_sector_i = 16'hABCD;
    expect_load(1'b1, 16'hABCD, 1'b1, 1'b0);
    rd0 = rd_total;
    pulse(1'b0);
    idle_cycles(1);
    auto_int_i = 1'b0;
    while (!otp_active_o) @(negedge clk);
    idle_cycles(10);
    chk(exp_q.size() == 0, "R3", "auto writes remaining", exp_q.size(), 0);
    chk(rd_total - rd0 == 2 * (k_reads + 1), "R4", "edge needs a low read first",
        rd_total - rd0, 2 * (k_reads + 1));
    push(16'hF220, 16'h00F0);
    pulse(1'b1);
    while (busy_o || otp_active_o) @(negedge clk);
    idle_cycles(5);

    // R5: flag never rises, small poll budget
    k_reads = 1000; poll_limit_i = 16'd5; dly = 1;
    push(16'hF100, 16'h0000); push(16'hF101, 16'h0000);
    push(16'hF241, 16'h0000); push(16'hF220, 16'h0065);
    die_sel_i = 1'b0;
    rd0 = rd_total;
    pulse(1'b0);
    while (!err_o) @(negedge clk);
    chk(rd_total - rd0 == 5, "R5", "reads before error", rd_total - rd0, 5);
    wr0 = wr_total;
    idle_cycles(30);
    chk(rd_total - rd0 == 5 && wr_total == wr0, "R5", "quiet in error",
        rd_total - rd0, 5);
    pulse(1'b0);
    idle_cycles(10);
    chk(err_o && !busy_o && wr_total == wr0, "R7", "start ignored in error",
        {err_o, busy_o}, 2);

    // R11: exit from error
    k_reads = 1; poll_limit_i = 16'd100;
    push(16'hF220, 16'h00F0);
    pulse(1'b1);
    while (busy_o || err_o) @(negedge clk);
    idle_cycles(5);
    chk(exp_q.size() == 0 && !err_o && !otp_active_o, "R11", "exit from error",
        exp_q.size(), 0);
    chk(hold_bad == 0, "R10", "strobe held until ready", hold_bad, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule